// File: doc/BRIEF.md
# Multi-mode 8-bit PWM timer

An 8-bit timer/counter with two compare channels and a waveform generator per channel. A 3-bit mode field picks the counting style (free-running wrap, clear-on-compare, single-slope fast PWM or dual-slope phase-correct PWM). It also picks whether the upper limit (TOP) is the all-ones MAX value or the channel A compare value. The counter advances only on cycles where the `tick` clock-enable input is high. Every effect of a tick (count change, flag set, pin change, compare reload) is decided from the count value held during that tick cycle and appears at the clock edge that ends it.

Software writes a control byte and the two compare values through simple write strobes. It reads the control byte back, and clears sticky flags by writing ones. In the PWM modes the compare values are double-buffered and reloaded when the counter reaches TOP. In the other modes a compare write takes effect at once. The waveform pins are low whenever their output control is disconnected or reserved, and whenever the mode itself is reserved.

Top module: `tc8_wavetimer`

## Requirements
- R1: After a synchronous active-low reset, `count` is 0, `flags` is 000, both waveform pins are 0 and `ctrl_rdata` is 0x00.
- R2: The mode is `ctrl[2:0]`. Mode 0 counts up and wraps from MAX to 0. Mode 2 counts up and returns to 0 on the tick after the count equals compare A. Modes 3 and 7 count up to TOP and return to 0 on the next tick. Modes 1 and 5 count up from 0 to TOP, then down to 0, then up again, turning at each end. TOP is MAX (0xFF) in modes 0, 1 and 3, and compare A in modes 2, 5 and 7. The count changes only at edges ending a cycle with `tick` high.
- R3: Modes 4 and 6 are reserved. In those modes the count holds, no flag is set and both pins stay 0.
- R4: In modes 0 and 2 a compare write takes effect at once. In modes 1, 3, 5 and 7 it goes to a buffer, which is loaded into the active compare value on the tick where the count equals TOP.
- R5: `flags[0]` (overflow) is set on the tick where the count equals MAX in modes 0, 2 and 3. It is set on the tick where the count turns upward at 0 in modes 1 and 5. It is set on the tick where the count equals TOP in mode 7.
- R6: `flags[1]` / `flags[2]` are set on a tick where the count equals the active compare value of channel A / B, in any non-reserved mode.
- R7: Flags are sticky. Writing `flag_clr_we` clears each flag whose bit in `flag_clr` is 1 (bit0 overflow, bit1 match A, bit2 match B). A set on the same cycle wins over the clear.
- R8: In modes 1 and 5 the pin control (`ctrl[5:4]` for B, `ctrl[7:6]` for A) behaves as follows. 00 and 01 leave the pin at 0. 10 clears the pin on a match while counting up and sets it on a match while counting down. 11 does the opposite.
- R9: In modes 1 and 5, when the compare value equals TOP and pin control is 10 or 11, the match is ignored. At TOP, 10 sets the pin and 11 clears it.
- R10: In modes 3 and 7, pin control 10 clears the pin on a match and sets it on the wrap tick at TOP. 11 does the opposite and 01 leaves the pin at 0. If both events fall on the same tick, the wrap action wins.
- R11: In modes 0 and 2, a match toggles the pin under control 01, clears it under 10 and sets it under 11.
- R12: `ctrl_rdata` returns the control byte with bit 3 reserved and always 0: [7:6] pin A control, [5:4] pin B control, [2:0] mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable (prescaled tick) |
| ctrl_we | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte write data |
| ctrl_rdata | output | 8 | Control byte read-back |
| cmp_a_we | input | 1 | Compare A write strobe |
| cmp_b_we | input | 1 | Compare B write strobe |
| cmp_wdata | input | W | Compare write data |
| flag_clr_we | input | 1 | Flag clear strobe |
| flag_clr | input | 3 | Flag clear mask (1 clears) |
| count | output | W | Counter value |
| wave_a | output | 1 | Waveform pin A |
| wave_b | output | 1 | Waveform pin B |
| flags | output | 3 | {match B, match A, overflow} |

## Verification
The bench builds the block with the default width of 8, so MAX is 0xFF. The full-range wrap, the MAX-based overflow and the 255-step phase-correct climb all fall within a few hundred ticks. Compare A values of 10 and 20 give short TOP-limited periods. These make the phase-correct turnaround, the buffered reload at TOP and the compare-equals-TOP special case reachable in tens of ticks.

// File: rtl/tc8_pkg.sv
// Shared types and mode decoders for the 8-bit waveform timer.
// Assumes the 3-bit mode encoding given in the brief (R2).
package tc8_pkg;

    typedef enum logic [2:0] {
        MD_NORMAL    = 3'd0,
        MD_PC_FULL   = 3'd1,
        MD_CTC       = 3'd2,
        MD_FAST_FULL = 3'd3,
        MD_RSV4      = 3'd4,
        MD_PC_A      = 3'd5,
        MD_RSV6      = 3'd6,
        MD_FAST_A    = 3'd7
    } tc8_mode_e;

    localparam int NCH    = 2;   // compare channels
    localparam int NFLAG  = 3;   // overflow, match A, match B

    function automatic logic mode_reserved(input tc8_mode_e m);
        return (m == MD_RSV4) || (m == MD_RSV6);
    endfunction

    function automatic logic mode_phase(input tc8_mode_e m);
        return (m == MD_PC_FULL) || (m == MD_PC_A);
    endfunction

    function automatic logic mode_fast(input tc8_mode_e m);
        return (m == MD_FAST_FULL) || (m == MD_FAST_A);
    endfunction

    function automatic logic mode_pwm(input tc8_mode_e m);
        return mode_phase(m) || mode_fast(m);
    endfunction

    function automatic logic mode_top_a(input tc8_mode_e m);
        return (m == MD_CTC) || (m == MD_PC_A) || (m == MD_FAST_A);
    endfunction

endpackage

// File: rtl/tc8_counter.sv
// Counter core: holds the count and direction, picks TOP, and reports
// the per-tick events (TOP reached, overflow) used by the other units.
// Assumes: all events are decided from the count held in the tick cycle.
module tc8_counter
    import tc8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  tc8_mode_e    mode,
    input  logic [W-1:0] top_a,
    output logic [W-1:0] count,
    output logic         up,
    output logic [W-1:0] top,
    output logic         run,
    output logic         top_evt,
    output logic         ovf_evt
);

    localparam logic [W-1:0] MAXV = {W{1'b1}};
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_q, cnt_d;
    logic         up_q, up_d;
    logic         at_top;

    // TOP source and tick qualification
    assign top    = mode_top_a(mode) ? top_a : MAXV;
    assign run    = tick && !mode_reserved(mode);
    assign at_top = (cnt_q == top);

    // next count and direction for the selected mode
    always_comb begin
        cnt_d = cnt_q;
        up_d  = 1'b1;
        case (mode)
            MD_NORMAL: cnt_d = cnt_q + ONE;
            MD_CTC:    cnt_d = at_top ? '0 : cnt_q + ONE;
            MD_FAST_FULL, MD_FAST_A: cnt_d = at_top ? '0 : cnt_q + ONE;
            MD_PC_FULL, MD_PC_A: begin
                if (up_q) begin
                    if (at_top) begin
                        up_d  = 1'b0;
                        cnt_d = (cnt_q == '0) ? '0 : cnt_q - ONE;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end else if (cnt_q == '0) begin
                    up_d  = 1'b1;
                    cnt_d = (top == '0) ? '0 : ONE;
                end else begin
                    up_d  = 1'b0;
                    cnt_d = cnt_q - ONE;
                end
            end
            default: begin
                cnt_d = cnt_q;
                up_d  = up_q;
            end
        endcase
    end

    // count and direction registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else if (run) begin
            cnt_q <= cnt_d;
            up_q  <= up_d;
        end
    end

    // per-tick events seen by flags, compare reload and waveform units
    assign top_evt = run && at_top;
    assign ovf_evt = run && (
        (((mode == MD_NORMAL) || (mode == MD_CTC) || (mode == MD_FAST_FULL)) && (cnt_q == MAXV)) ||
        (mode_phase(mode) && !up_q && (cnt_q == '0)) ||
        ((mode == MD_FAST_A) && at_top));

    assign count = cnt_q;
    assign up    = up_q;

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));
    a_r3_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mode_reserved(mode) |=> $stable(count));
    a_r2_ctc_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (mode == MD_CTC) && (count == top_a)) |=> (count == '0));
    a_r2_pc_turn_up: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode_phase(mode) && !up && (count == '0) && (top != '0)) |=> (up && count == ONE));

endmodule

// File: rtl/tc8_cmpreg.sv
// One compare channel: a write buffer plus the active compare value.
// Assumes: pwm selects buffered reload at TOP, otherwise writes are direct.
module tc8_cmpreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic         pwm,
    input  logic         load_top,
    output logic [W-1:0] active
);

    logic [W-1:0] buf_q, act_q;

    // buffer captures every write; active is direct or reloaded at TOP
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
            act_q <= '0;
        end else begin
            if (we) buf_q <= wdata;
            if (we && !pwm)          act_q <= wdata;
            else if (pwm && load_top) act_q <= buf_q;
        end
    end

    assign active = act_q;

    a_r4_buffer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && !load_top) |=> $stable(active));

endmodule

// File: rtl/tc8_wavegen.sv
// Waveform unit for one pin: applies the 2-bit pin control per mode.
// Assumes: events come from the counter core in the same tick cycle.
module tc8_wavegen
    import tc8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  tc8_mode_e    mode,
    input  logic [1:0]   com,
    input  logic         run,
    input  logic         up,
    input  logic         top_evt,
    input  logic [W-1:0] count,
    input  logic [W-1:0] cmp,
    input  logic [W-1:0] top,
    output logic         pin
);

    logic lvl_q;
    logic match;
    logic conn;

    assign match = run && (count == cmp);

    // waveform level update on compare, TOP and wrap events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
        end else if (run) begin
            if (mode_phase(mode)) begin
                if (com[1]) begin
                    if (top_evt && (cmp == top)) lvl_q <= ~com[0];
                    else if (match)              lvl_q <= up ? com[0] : ~com[0];
                end
            end else if (mode_fast(mode)) begin
                if (com[1]) begin
                    if (top_evt)    lvl_q <= ~com[0];
                    else if (match) lvl_q <= com[0];
                end
            end else if (match) begin
                case (com)
                    2'b01:        lvl_q <= ~lvl_q;
                    2'b10, 2'b11: lvl_q <= com[0];
                    default:      lvl_q <= lvl_q;
                endcase
            end
        end
    end

    // pin is driven only for a valid control code in a valid mode
    assign conn = !mode_reserved(mode) && (com[1] || ((com == 2'b01) && !mode_pwm(mode)));
    assign pin  = conn && lvl_q;

    a_r10_fast_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (top_evt && mode_fast(mode) && (com == 2'b10)) |=> lvl_q);
    a_r9_top_equal_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (top_evt && mode_phase(mode) && (com == 2'b10) && (cmp == top)) |=> lvl_q);
    a_r8_pc_up_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (match && up && mode_phase(mode) && (com == 2'b10) && (cmp != top)) |=> !lvl_q);

endmodule

// File: rtl/tc8_wavetimer.sv
// Top: control register, two compare channels with waveform pins,
// counter core and sticky write-one-to-clear flags.
// Assumes: control byte layout per R12; flag bit order per R7.
module tc8_wavetimer
    import tc8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         ctrl_we,
    input  logic [7:0]   ctrl_wdata,
    output logic [7:0]   ctrl_rdata,
    input  logic         cmp_a_we,
    input  logic         cmp_b_we,
    input  logic [W-1:0] cmp_wdata,
    input  logic         flag_clr_we,
    input  logic [2:0]   flag_clr,
    output logic [W-1:0] count,
    output logic         wave_a,
    output logic         wave_b,
    output logic [2:0]   flags
);

    tc8_mode_e          mode_q;
    logic [1:0]         com_q   [NCH];
    logic [NCH-1:0]     cmp_we;
    logic [W-1:0]       cmp_act [NCH];
    logic [NCH-1:0]     pin;
    logic [W-1:0]       top;
    logic               up, run, top_evt, ovf_evt;
    logic [NFLAG-1:0]   flag_q, flag_set, flag_clear;

    // control register: mode and per-pin control fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MD_NORMAL;
            com_q[0] <= 2'b00;
            com_q[1] <= 2'b00;
        end else if (ctrl_we) begin
            mode_q   <= tc8_mode_e'(ctrl_wdata[2:0]);
            com_q[1] <= ctrl_wdata[5:4];
            com_q[0] <= ctrl_wdata[7:6];
        end
    end

    assign ctrl_rdata = {com_q[0], com_q[1], 1'b0, mode_q};
    assign cmp_we     = {cmp_b_we, cmp_a_we};

    tc8_counter #(.W(W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .mode    (mode_q),
        .top_a   (cmp_act[0]),
        .count   (count),
        .up      (up),
        .top     (top),
        .run     (run),
        .top_evt (top_evt),
        .ovf_evt (ovf_evt)
    );

    for (genvar c = 0; c < NCH; c++) begin : gen_ch
        tc8_cmpreg #(.W(W)) u_cmp (
            .clk      (clk),
            .rst_n    (rst_n),
            .we       (cmp_we[c]),
            .wdata    (cmp_wdata),
            .pwm      (mode_pwm(mode_q)),
            .load_top (top_evt),
            .active   (cmp_act[c])
        );
        tc8_wavegen #(.W(W)) u_wave (
            .clk     (clk),
            .rst_n   (rst_n),
            .mode    (mode_q),
            .com     (com_q[c]),
            .run     (run),
            .up      (up),
            .top_evt (top_evt),
            .count   (count),
            .cmp     (cmp_act[c]),
            .top     (top),
            .pin     (pin[c])
        );
        assign flag_set[c+1] = run && (count == cmp_act[c]);
    end

    assign flag_set[0] = ovf_evt;
    assign flag_clear  = flag_clr_we ? flag_clr : '0;

    // sticky flags: event set wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~flag_clear) | flag_set;
    end

    assign flags  = flag_q;
    assign wave_a = pin[0];
    assign wave_b = pin[1];

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && flags == '0 && ctrl_rdata == 8'h00));
    a_r12_reserved_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> (ctrl_rdata[3] == 1'b0));
    for (genvar f = 0; f < NFLAG; f++) begin : gen_flag_chk
        a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[f] && !(flag_clr_we && flag_clr[f])) |=> flags[f]);
    end

endmodule

// File: tb/test_tc8_wavetimer.sv
module test_tc8_wavetimer;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    typedef struct packed {
        logic [2:0]  mode;
        logic [7:0]  cmpa;
        logic [15:0] n;
        logic [7:0]  cnt;
        logic        ovf;
        logic        mfa;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VT [NV] = '{
        '{3'd0, 8'd10, 16'd5,   8'd5,   1'b0, 1'b0},
        '{3'd0, 8'd10, 16'd260, 8'd4,   1'b1, 1'b1},
        '{3'd2, 8'd10, 16'd11,  8'd0,   1'b0, 1'b1},
        '{3'd2, 8'd10, 16'd15,  8'd4,   1'b0, 1'b1},
        '{3'd3, 8'd10, 16'd300, 8'd44,  1'b1, 1'b1},
        '{3'd7, 8'd20, 16'd15,  8'd15,  1'b0, 1'b0},
        '{3'd7, 8'd20, 16'd25,  8'd4,   1'b1, 1'b1},
        '{3'd5, 8'd10, 16'd13,  8'd7,   1'b0, 1'b1},
        '{3'd5, 8'd10, 16'd25,  8'd5,   1'b1, 1'b1},
        '{3'd1, 8'd10, 16'd256, 8'd254, 1'b0, 1'b1},
        '{3'd4, 8'd10, 16'd10,  8'd0,   1'b0, 1'b0},
        '{3'd6, 8'd10, 16'd10,  8'd0,   1'b0, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst_n, tick, ctrl_we, cmp_a_we, cmp_b_we, flag_clr_we;
    logic [7:0]   ctrl_wdata, ctrl_rdata;
    logic [W-1:0] cmp_wdata, count;
    logic [2:0]   flag_clr, flags;
    logic         wave_a, wave_b;
    int           n_chk = 0;
    int           n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tc8_wavetimer #(.W(W)) i_tc8_wavetimer (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
        .cmp_a_we(cmp_a_we), .cmp_b_we(cmp_b_we), .cmp_wdata(cmp_wdata),
        .flag_clr_we(flag_clr_we), .flag_clr(flag_clr),
        .count(count), .wave_a(wave_a), .wave_b(wave_b), .flags(flags)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick = 1'b0; ctrl_we = 1'b0; cmp_a_we = 1'b0; cmp_b_we = 1'b0;
        flag_clr_we = 1'b0; ctrl_wdata = '0; cmp_wdata = '0; flag_clr = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic wr_a(input logic [7:0] v);
        @(negedge clk); cmp_a_we = 1'b1; cmp_wdata = v;
        @(negedge clk); cmp_a_we = 1'b0;
    endtask

    task automatic wr_b(input logic [7:0] v);
        @(negedge clk); cmp_b_we = 1'b1; cmp_wdata = v;
        @(negedge clk); cmp_b_we = 1'b0;
    endtask

    task automatic clr(input logic [2:0] m);
        @(negedge clk); flag_clr_we = 1'b1; flag_clr = m;
        @(negedge clk); flag_clr_we = 1'b0; flag_clr = '0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk); tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        @(negedge clk);
        check("R1 count", count, 0);
        check("R1 flags", flags, 0);
        check("R1 pins", {wave_a, wave_b}, 0);
        check("R1 ctrl", ctrl_rdata, 0);

        // table: counting sequences, overflow and match-A flags per mode
        for (int i = 0; i < NV; i++) begin
            do_reset();
            wr_a(VT[i].cmpa);
            wr_ctrl({4'b0010, 1'b0, VT[i].mode});
            ticks(int'(VT[i].n));
            check("R2/R3 count", count, VT[i].cnt);
            check("R5 overflow", flags[0], VT[i].ovf);
            check("R6 match A", flags[1], VT[i].mfa);
            repeat (3) @(negedge clk);
            check("R2 hold without tick", count, VT[i].cnt);
            if (VT[i].mode == 3'd4 || VT[i].mode == 3'd6)
                check("R3 reserved pin low", wave_b, 0);
        end

        // R12 reserved bit reads zero
        do_reset();
        wr_ctrl(8'hFF);
        check("R12 readback", ctrl_rdata, 8'hF7);

        // R7 write-one-to-clear
        do_reset();
        wr_a(8'd10); wr_b(8'd20);
        ticks(260);
        check("R7 all set", flags, 3'b111);
        clr(3'b001);
        check("R7 clear overflow only", flags, 3'b110);
        clr(3'b110);
        check("R7 clear matches", flags, 3'b000);

        // R4 buffered reload in mode 7
        do_reset();
        wr_a(8'd20); wr_ctrl(8'h07);
        ticks(3);
        wr_a(8'd5);
        ticks(5);
        check("R4 buffered not yet active", count, 8);
        ticks(13);
        check("R4 wrap at old TOP", count, 0);
        ticks(5);
        check("R4 new TOP reached", count, 5);
        ticks(1);
        check("R4 wrap at new TOP", count, 0);

        // R4 immediate update in CTC
        do_reset();
        wr_a(8'd10); wr_ctrl(8'h02);
        ticks(3);
        wr_a(8'd5);
        ticks(2);
        check("R4 ctc at new compare", count, 5);
        ticks(1);
        check("R4 ctc immediate clear", count, 0);

        // R8 phase-correct control 10
        do_reset();
        wr_a(8'd10); wr_b(8'd4); wr_ctrl(8'h25);
        ticks(16);
        check("R8 10 before down match", wave_b, 0);
        ticks(1);
        check("R8 10 set on down match", wave_b, 1);
        ticks(7);
        check("R8 10 before up match", wave_b, 1);
        ticks(1);
        check("R8 10 clear on up match", wave_b, 0);

        // R8 phase-correct control 11
        do_reset();
        wr_a(8'd10); wr_b(8'd4); wr_ctrl(8'h35);
        ticks(5);
        check("R8 11 set on up match", wave_b, 1);
        ticks(12);
        check("R8 11 clear on down match", wave_b, 0);

        // R8 phase-correct control 01 stays low
        do_reset();
        wr_a(8'd10); wr_b(8'd4); wr_ctrl(8'h15);
        ticks(17);
        check("R8 01 reserved low", wave_b, 0);

        // R9 compare equals TOP
        do_reset();
        wr_a(8'd10); wr_b(8'd10); wr_ctrl(8'h25);
        ticks(11);
        check("R9 10 set at TOP", wave_b, 1);
        ticks(20);
        check("R9 10 stays set", wave_b, 1);
        wr_ctrl(8'h35);
        ticks(20);
        check("R9 11 clear at TOP", wave_b, 0);

        // R10 fast PWM control 10
        do_reset();
        wr_a(8'd20); wr_b(8'd5); wr_ctrl(8'h27);
        ticks(21);
        check("R10 set at wrap", wave_b, 1);
        ticks(5);
        check("R10 held before match", wave_b, 1);
        ticks(1);
        check("R10 clear on match", wave_b, 0);

        // R11 normal mode toggle
        do_reset();
        wr_b(8'd3); wr_ctrl(8'h10);
        ticks(4);
        check("R11 toggle high", wave_b, 1);
        ticks(256);
        check("R11 toggle low", wave_b, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule